// File: doc/BRIEF.md
# System Exception Pending Controller

This block keeps the pending state of three system exceptions: a non-maskable exception (number 2), a deferred software service call (number 14) and a periodic timer tick (number 15). It also takes a parameterised set of external interrupt lines (numbers 16 and up) whose pending state is held outside the block. Software works through one 32-bit control/status word. Writing a 1 to a dedicated set bit or clear bit changes one flag, and writing 0 leaves it alone. Reading the word returns the flags, the number of the most urgent pending enabled exception and the number of the exception now being handled.

The selected exception goes to the core on a valid/ready stream. `vec_valid` is high whenever some enabled exception is pending, and `vec_num` carries its number. The core accepts by raising `vec_ready`. Back-pressure has no cost: while `vec_ready` is low nothing changes, and `vec_num` may move to a more urgent number at any time. The number that counts is the one shown in the cycle the handshake completes. That number becomes the active number, and the internal flag it belongs to is cleared. `exc_done` returns the core to thread mode (active number 0). A handshake and `exc_done` in the same cycle resolve in favour of the handshake. `N_EXT` must not exceed 48, so that every number fits in six bits.

Top module: `exc_pend_ctrl`

## Requirements
- R1: After reset, `csr_rdata`, `vec_valid`, `vec_num` and `active_num` are all 0.
- R2: A write with bit 31 set makes the non-maskable exception pending, and bit 31 of the read word shows that state. A rising edge of `nmi_req` also makes it pending. Writing 0 to bit 31 has no effect.
- R3: Bit 28 written as 1 sets the service call pending and bit 27 clears it. Bit 26 written as 1, or `tick_req` high, sets the timer pending, and bit 25 clears it. Read bits 28 and 26 show these flags. Zeros in these positions change nothing.
- R4: Read bits 27 and 25 (the clear bits) are always 0. Bits 30:29, 24:23, 21:18 and 11:9 also read as 0.
- R5: When the set and clear bits of one exception are written as 1 together, the flag ends at 0. A clear also beats a `tick_req` in the same cycle.
- R6: Read bits 17:12 and `vec_num` give the number of the most urgent pending enabled exception, and 0 means none. The non-maskable exception outranks everything. Among the others, a lower priority value wins. An external line counts only while its enable is high. `vec_valid` is high exactly when this number is nonzero.
- R7: When two candidates have equal priority value, the lower exception number is chosen.
- R8: Read bit 22 is 1 when the service call, the timer or any external line is pending, whether or not that line is enabled. The non-maskable exception does not count.
- R9: A cycle with `vec_valid` and `vec_ready` both high sets the active number (read bits 8:0 and `active_num`) to `vec_num` from the next cycle on. It also clears the internal flag of that exception.
- R10: Entering the non-maskable handler clears its flag. A request level that stays high does not set the flag again; only a new rising edge of `nmi_req` does.
- R11: `exc_done` without a handshake returns the active number to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data: flags, selected number, active number |
| nmi_req | input | 1 | Non-maskable request level; a rising edge sets the flag |
| tick_req | input | 1 | Timer tick; high sets the timer flag |
| ext_pend | input | N_EXT | External pending lines |
| ext_en | input | N_EXT | External enables |
| pri_svc | input | PRI_W | Service call priority (lower is more urgent) |
| pri_tick | input | PRI_W | Timer priority |
| pri_ext | input | N_EXT*PRI_W | External priorities, line i at bits i*PRI_W |
| vec_valid | output | 1 | A pending enabled exception is offered |
| vec_num | output | 6 | Offered exception number |
| vec_ready | input | 1 | Core accepts the offered exception |
| exc_done | input | 1 | Core returns to thread mode |
| active_num | output | 9 | Active exception number, 0 in thread mode |

## Verification
The bench builds the block with `N_EXT = 4` and `PRI_W = 3`. It ties the service call to priority 4, the timer to 2 and the external lines to 2, 1, 4 and 7. With these values the timer and external line 0 meet in an exact tie, so the lower-number rule can be observed. An external line outranks both system exceptions. A disabled line can hold bit 22 high without being chosen, and the non-maskable exception outranks a line of worse priority.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;
  localparam int unsigned EXC_NUM_W = 6;
  localparam int unsigned ACT_W     = 9;
  localparam int unsigned N_INT     = 3;

  localparam logic [EXC_NUM_W-1:0] NMI_NUM  = 6'd2;
  localparam logic [EXC_NUM_W-1:0] SVC_NUM  = 6'd14;
  localparam logic [EXC_NUM_W-1:0] TICK_NUM = 6'd15;
  localparam int unsigned          EXT_BASE = 16;

  // control word bit positions (decoded by software)
  localparam int unsigned B_NMI_SET  = 31;
  localparam int unsigned B_SVC_SET  = 28;
  localparam int unsigned B_SVC_CLR  = 27;
  localparam int unsigned B_TICK_SET = 26;
  localparam int unsigned B_TICK_CLR = 25;
  localparam int unsigned B_ISR      = 22;
  localparam int unsigned VEC_LSB    = 12;

  // internal source slots, in ascending exception number
  typedef enum logic [1:0] {
    SRC_NMI  = 2'd0,
    SRC_SVC  = 2'd1,
    SRC_TICK = 2'd2
  } int_src_e;
endpackage

// File: rtl/exc_rise_det.sv
module exc_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/exc_pend_flag.sv
module exc_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic pend_o
);
  // precedence: software clear, then any set, then handler entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (clr_i)  pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (take_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int unsigned N_SRC = 7,
  parameter int unsigned KEY_W = 4,
  parameter int unsigned NUM_W = 6
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*KEY_W-1:0] key_i,
  input  logic [N_SRC*NUM_W-1:0] num_i,
  output logic                   found_o,
  output logic [NUM_W-1:0]       num_o
);
  logic [KEY_W-1:0] best_key;

  // sources arrive in ascending number order; strict compare keeps the
  // lower number on equal keys
  always_comb begin
    found_o  = 1'b0;
    best_key = '1;
    num_o    = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (req_i[i] && (!found_o || (key_i[i*KEY_W +: KEY_W] < best_key))) begin
        found_o  = 1'b1;
        best_key = key_i[i*KEY_W +: KEY_W];
        num_o    = num_i[i*NUM_W +: NUM_W];
      end
    end
  end
endmodule

// File: rtl/exc_pend_ctrl.sv
module exc_pend_ctrl
  import exc_pend_pkg::*;
#(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned PRI_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   csr_wr,
  input  logic [31:0]            csr_wdata,
  output logic [31:0]            csr_rdata,
  input  logic                   nmi_req,
  input  logic                   tick_req,
  input  logic [N_EXT-1:0]       ext_pend,
  input  logic [N_EXT-1:0]       ext_en,
  input  logic [PRI_W-1:0]       pri_svc,
  input  logic [PRI_W-1:0]       pri_tick,
  input  logic [N_EXT*PRI_W-1:0] pri_ext,
  output logic                   vec_valid,
  output logic [EXC_NUM_W-1:0]   vec_num,
  input  logic                   vec_ready,
  output logic [ACT_W-1:0]       active_num,
  input  logic                   exc_done
);
  localparam int unsigned KEY_W = PRI_W + 1;
  localparam int unsigned N_SRC = N_INT + N_EXT;

  logic               nmi_rise;
  logic               take_hs;
  logic [N_INT-1:0]   f_set, f_clr, f_take, f_pend;
  logic [N_SRC-1:0]   c_req;
  logic [N_SRC*KEY_W-1:0] c_key;
  logic [N_SRC*NUM_W_L-1:0] c_num;
  logic [ACT_W-1:0]   active_q;
  logic               unused_wdata;

  assign unused_wdata = ^{csr_wdata[30:29], csr_wdata[24:0]};

  exc_rise_det u_nmi_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (nmi_req),
    .rise_o (nmi_rise)
  );

  assign take_hs = vec_valid & vec_ready;

  always_comb begin
    f_set[SRC_NMI]  = (csr_wr & csr_wdata[B_NMI_SET]) | nmi_rise;
    f_clr[SRC_NMI]  = 1'b0;
    f_take[SRC_NMI] = take_hs & (vec_num == NMI_NUM);

    f_set[SRC_SVC]  = csr_wr & csr_wdata[B_SVC_SET];
    f_clr[SRC_SVC]  = csr_wr & csr_wdata[B_SVC_CLR];
    f_take[SRC_SVC] = take_hs & (vec_num == SVC_NUM);

    f_set[SRC_TICK]  = (csr_wr & csr_wdata[B_TICK_SET]) | tick_req;
    f_clr[SRC_TICK]  = csr_wr & csr_wdata[B_TICK_CLR];
    f_take[SRC_TICK] = take_hs & (vec_num == TICK_NUM);
  end

  for (genvar g = 0; g < int'(N_INT); g++) begin : g_flag
    exc_pend_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .take_i (f_take[g]),
      .pend_o (f_pend[g])
    );
  end

  // candidate list: non-maskable key is 0, every other key has MSB 1
  assign c_req[0] = f_pend[SRC_NMI];
  assign c_key[0 +: KEY_W] = '0;
  assign c_num[0 +: NUM_W_L] = NMI_NUM;

  assign c_req[1] = f_pend[SRC_SVC];
  assign c_key[KEY_W +: KEY_W] = {1'b1, pri_svc};
  assign c_num[NUM_W_L +: NUM_W_L] = SVC_NUM;

  assign c_req[2] = f_pend[SRC_TICK];
  assign c_key[2*KEY_W +: KEY_W] = {1'b1, pri_tick};
  assign c_num[2*NUM_W_L +: NUM_W_L] = TICK_NUM;

  for (genvar e = 0; e < int'(N_EXT); e++) begin : g_ext
    assign c_req[N_INT+e] = ext_pend[e] & ext_en[e];
    assign c_key[(N_INT+e)*KEY_W +: KEY_W] = {1'b1, pri_ext[e*PRI_W +: PRI_W]};
    assign c_num[(N_INT+e)*NUM_W_L +: NUM_W_L] = NUM_W_L'(EXT_BASE + e);
  end

  exc_prio_pick #(
    .N_SRC (N_SRC),
    .KEY_W (KEY_W),
    .NUM_W (NUM_W_L)
  ) u_pick (
    .req_i   (c_req),
    .key_i   (c_key),
    .num_i   (c_num),
    .found_o (vec_valid),
    .num_o   (vec_num)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        active_q <= '0;
    else if (take_hs)  active_q <= {{(ACT_W-EXC_NUM_W){1'b0}}, vec_num};
    else if (exc_done) active_q <= '0;
  end

  assign active_num = active_q;

  always_comb begin
    csr_rdata                             = '0;
    csr_rdata[B_NMI_SET]                  = f_pend[SRC_NMI];
    csr_rdata[B_SVC_SET]                  = f_pend[SRC_SVC];
    csr_rdata[B_TICK_SET]                 = f_pend[SRC_TICK];
    csr_rdata[B_ISR]                      = f_pend[SRC_SVC] | f_pend[SRC_TICK] | (|ext_pend);
    csr_rdata[VEC_LSB +: EXC_NUM_W]       = vec_num;
    csr_rdata[ACT_W-1:0]                  = active_q;
  end

  localparam int unsigned NUM_W_L = EXC_NUM_W;
endmodule

// File: rtl/exc_pend_ctrl_chk.sv
module exc_pend_ctrl_chk
  import exc_pend_pkg::*;
#(
  parameter int unsigned N_EXT = 4,
  parameter int unsigned PRI_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 csr_wr,
  input logic [31:0]          csr_wdata,
  input logic [31:0]          csr_rdata,
  input logic                 nmi_req,
  input logic                 vec_valid,
  input logic [EXC_NUM_W-1:0] vec_num,
  input logic                 vec_ready,
  input logic [ACT_W-1:0]     active_num,
  input logic                 exc_done
);
  AST_CLR_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[B_SVC_CLR] == 1'b0) && (csr_rdata[B_TICK_CLR] == 1'b0)); // R4

  AST_VEC_FIELD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[VEC_LSB +: EXC_NUM_W] == vec_num) && (vec_valid == (vec_num != '0))); // R6

  AST_NMI_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[B_NMI_SET] |-> (vec_num == NMI_NUM)); // R6

  AST_SVC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[B_SVC_SET] && !csr_wdata[B_SVC_CLR]) |=> csr_rdata[B_SVC_SET]); // R3

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[B_SVC_SET] && csr_wdata[B_SVC_CLR]) |=> !csr_rdata[B_SVC_SET]); // R5

  AST_ENTRY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> (active_num == {3'b000, $past(vec_num)})); // R9

  AST_ACTIVE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[ACT_W-1:0] == active_num); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_done && !(vec_valid && vec_ready)) |=> (active_num == '0)); // R11

  AST_NMI_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |=> csr_rdata[B_NMI_SET]); // R10
endmodule

bind exc_pend_ctrl exc_pend_ctrl_chk #(
  .N_EXT (N_EXT),
  .PRI_W (PRI_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_wr     (csr_wr),
  .csr_wdata  (csr_wdata),
  .csr_rdata  (csr_rdata),
  .nmi_req    (nmi_req),
  .vec_valid  (vec_valid),
  .vec_num    (vec_num),
  .vec_ready  (vec_ready),
  .active_num (active_num),
  .exc_done   (exc_done)
);

// File: tb/sim_exc_pend_ctrl.sv
module sim_exc_pend_ctrl;
  localparam int N_EXT = 4;
  localparam int PRI_W = 3;
  localparam int N_VEC = 11;
  localparam int VEC_W = 74;

  // {wr, wdata[32], tick, ext_pend[4], ext_en[4], expected rdata[32]}
  localparam logic [VEC_W-1:0] TBL [N_VEC] = '{
    {1'b0, 32'h0000_0000, 1'b0, 4'h0, 4'h0, 32'h0000_0000}, // idle          R6
    {1'b1, 32'h1000_0000, 1'b0, 4'h0, 4'h0, 32'h1040_E000}, // svc set       R3 R8
    {1'b0, 32'h0000_0000, 1'b1, 4'h0, 4'h0, 32'h1440_F000}, // tick, pri 2   R3 R6
    {1'b0, 32'h0000_0000, 1'b0, 4'h1, 4'h1, 32'h1440_F000}, // tie 15 vs 16  R7
    {1'b0, 32'h0000_0000, 1'b0, 4'h3, 4'h3, 32'h1441_1000}, // ext1 pri 1    R6
    {1'b0, 32'h0000_0000, 1'b0, 4'h2, 4'h0, 32'h1440_F000}, // disabled ext  R6 R8
    {1'b1, 32'h1800_0000, 1'b0, 4'h0, 4'h0, 32'h0440_F000}, // set+clr svc   R5
    {1'b1, 32'h0200_0000, 1'b1, 4'h0, 4'h0, 32'h0000_0000}, // clr vs tick   R5
    {1'b1, 32'h8000_0000, 1'b0, 4'h0, 4'h0, 32'h8000_2000}, // nmi set       R2 R8
    {1'b1, 32'h0000_0000, 1'b0, 4'h0, 4'h0, 32'h8000_2000}, // zeros ignored R2 R3
    {1'b1, 32'h1000_0000, 1'b0, 4'h8, 4'h8, 32'h9040_2000}  // nmi on top    R6
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   csr_wr = 1'b0;
  logic [31:0]            csr_wdata = '0;
  logic [31:0]            csr_rdata;
  logic                   nmi_req = 1'b0;
  logic                   tick_req = 1'b0;
  logic [N_EXT-1:0]       ext_pend = '0;
  logic [N_EXT-1:0]       ext_en = '0;
  logic [PRI_W-1:0]       pri_svc = 3'd4;
  logic [PRI_W-1:0]       pri_tick = 3'd2;
  logic [N_EXT*PRI_W-1:0] pri_ext = {3'd7, 3'd4, 3'd1, 3'd2};
  logic                   vec_valid;
  logic [5:0]             vec_num;
  logic                   vec_ready = 1'b0;
  logic [8:0]             active_num;
  logic                   exc_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  exc_pend_ctrl #(.N_EXT(N_EXT), .PRI_W(PRI_W)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .nmi_req(nmi_req), .tick_req(tick_req),
    .ext_pend(ext_pend), .ext_en(ext_en), .pri_svc(pri_svc),
    .pri_tick(pri_tick), .pri_ext(pri_ext), .vec_valid(vec_valid),
    .vec_num(vec_num), .vec_ready(vec_ready), .active_num(active_num),
    .exc_done(exc_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge, then drop the single-cycle strobes
  task automatic tick_once();
    @(posedge clk);
    @(negedge clk);
    csr_wr    = 1'b0;
    csr_wdata = '0;
    tick_req  = 1'b0;
    vec_ready = 1'b0;
    exc_done  = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #40000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", csr_rdata, 32'h0);
    check("R1 vec_valid", {31'b0, vec_valid}, 32'h0);
    check("R1 active", {23'b0, active_num}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      csr_wr    = TBL[i][73];
      csr_wdata = TBL[i][72:41];
      tick_req  = TBL[i][40];
      ext_pend  = TBL[i][39:36];
      ext_en    = TBL[i][35:32];
      tick_once();
      check($sformatf("R2-R8 vector %0d", i), csr_rdata, TBL[i][31:0]);
      check($sformatf("R6 vec_num vector %0d", i), {26'b0, vec_num}, {26'b0, TBL[i][17:12]});
    end

    // R9: accept the non-maskable exception
    vec_ready = 1'b1;
    tick_once();
    check("R9 nmi entry rdata", csr_rdata, 32'h1040_E002);
    check("R9 active", {23'b0, active_num}, 32'd2);

    // R9: accept the service call, external 3 remains
    vec_ready = 1'b1;
    tick_once();
    check("R9 svc entry rdata", csr_rdata, 32'h0041_300E);
    check("R9 vec_valid", {31'b0, vec_valid}, 32'h1);

    // R11: return to thread mode
    exc_done = 1'b1;
    tick_once();
    check("R11 done rdata", csr_rdata, 32'h0041_3000);

    // R10: request edge, entry, held level, new edge
    ext_pend = '0;
    ext_en   = '0;
    nmi_req  = 1'b1;
    tick_once();
    check("R10 edge sets", csr_rdata, 32'h8000_2000);
    vec_ready = 1'b1;
    tick_once();
    check("R10 entry clears", csr_rdata, 32'h0000_0002);
    tick_once();
    check("R10 held level ignored", csr_rdata, 32'h0000_0002);
    nmi_req = 1'b0;
    tick_once();
    check("R10 low level", csr_rdata, 32'h0000_0002);
    nmi_req = 1'b1;
    tick_once();
    check("R10 new edge sets", csr_rdata, 32'h8000_2002);

    // R11: done again, ready without valid changes nothing
    nmi_req  = 1'b0;
    exc_done = 1'b1;
    tick_once();
    check("R11 done with nmi pending", csr_rdata, 32'h8000_2000);
    vec_ready = 1'b1;
    tick_once();
    check("R9 second nmi entry", {23'b0, active_num}, 32'd2);
    vec_ready = 1'b1;
    tick_once();
    check("R9 ready without valid", csr_rdata, 32'h0000_0002);

    summary();
  end
endmodule